// File: doc/BRIEF.md
# Key Event Queue with Overflow Control

This block holds the key press and release events produced by a keypad scanner until a host collects them. Each event is one byte: the top bit says whether the key went down (1) or up (0), and the low seven bits carry the key code. Up to ten events are held in arrival order. A host reaches the block through a plain read/write strobe interface with a small register window. The host can read a configuration register, a status register with two sticky flags, the number of events held, and ten event addresses that all take from the same queue head.

On every event the block raises a key-event flag. When an event arrives while all ten slots are taken, it raises an overflow flag. A configuration bit then decides the outcome: the new event is thrown away, or it replaces the oldest entry. A single interrupt output combines each flag with its own enable. The key-event flag refuses to clear while the queue still holds anything, so the host is prompted again until it has drained every entry.

Top module: `keyevt_queue`

## Requirements
- R1: After reset the event count is 0, the configuration register (address 0) and the status register (address 1) read 0x00, and `irq` is low.
- R2: An event presented on `ev_valid` is stored as the byte {`ev_press`, `ev_key`}: bit 7 is 1 for a press and 0 for a release, and bits 6:0 are the key code. Events come out oldest first.
- R3: A read strobe at any of addresses 3 to 12 returns the oldest held event on `host_rdata` in the same cycle and removes that event at the clock edge. A read strobe at any other address removes nothing.
- R4: A read strobe at an event address while the queue is empty returns 0x00 and leaves the count at 0.
- R5: Address 2 returns the number of held events in bits 3:0. The count goes from 0 to 10 and never exceeds 10.
- R6: When configuration bit 2 is 0 and an event arrives while 10 events are held and no removal occurs in that cycle, the event is discarded, the contents are unchanged, and status bit 1 (overflow) is set.
- R7: When configuration bit 2 is 1 and an event arrives while the queue is full, the new event is appended, the oldest event is dropped, the count stays 10, and status bit 1 is set.
- R8: Every arriving event sets status bit 0 (key event). Writing 1 to status bit 0 clears it when the queue is empty.
- R9: While the count is nonzero, writing 1 to status bit 0 leaves it set.
- R10: `irq` is high exactly when (status bit 0 AND configuration bit 0) OR (status bit 1 AND configuration bit 1).
- R11: An event arrival and an event-address read strobe in the same cycle both take effect. When the queue was not empty, the count is unchanged. When it was empty, the read returns 0x00 and the count becomes 1.
- R12: Writing 1 to status bit 1 clears the overflow flag unless a new overflow occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | One-cycle strobe: an event is presented |
| ev_press | input | 1 | 1 = key pressed, 0 = key released |
| ev_key | input | 7 | Key code of the event |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 5 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data; valid in the cycle of `host_rd`, 0 otherwise |
| irq | output | 1 | Interrupt, the enabled flags ORed together |

## Verification
Read data is combinational: it is valid in the cycle the read strobe is high. The queue removal, the count change, flag updates and `irq` all take effect at the next rising edge, through a single register stage. The bench therefore drives each strobe just after a falling edge and samples `host_rdata` 1 ns later, before the rising edge that pops the entry. Counts, flags and `irq` are observed only on a later strobe or at a later falling edge, once the register stage has updated. Same-cycle arrival and removal is driven in a single strobe cycle, so that its one-edge effect on the count can be checked on its own.

// File: rtl/keyevt_pkg.sv
package keyevt_pkg;

  localparam int unsigned DATA_W = 8;

  // register window
  localparam int unsigned ADR_CFG  = 0;
  localparam int unsigned ADR_STAT = 1;
  localparam int unsigned ADR_CNT  = 2;
  localparam int unsigned ADR_EVT0 = 3;

  // status flag positions
  localparam int unsigned ST_KE  = 0;
  localparam int unsigned ST_OVF = 1;
  localparam int unsigned ST_W   = 2;

  // configuration layout, bit 2 down to bit 0
  typedef struct packed {
    logic ovf_mode;  // 1 = overwrite oldest, 0 = discard new
    logic ovf_ien;
    logic ke_ien;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  // ring pointer step with wrap at depth
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // occupancy after one cycle of adds and takes
  function automatic int unsigned level_next(int unsigned lvl, logic add, logic take);
    return lvl + (add ? 1 : 0) - (take ? 1 : 0);
  endfunction

  // address falls in the aliased event window
  function automatic logic in_evt_window(int unsigned a, int unsigned depth);
    return (a >= ADR_EVT0) && (a < ADR_EVT0 + depth);
  endfunction

  // interrupt merge of masked flags
  function automatic logic irq_merge(logic [ST_W-1:0] flags, logic [ST_W-1:0] en);
    return |(flags & en);
  endfunction

endpackage

// File: rtl/keyevt_ring.sv
module keyevt_ring
  import keyevt_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  input  logic             overwrite,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] level,
  output logic             pop_ok,
  output logic             ovf_evt
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [W-1:0]     slot [DEPTH];
  logic             full_now;
  logic             store;
  logic             drop_old;
  logic             rd_adv;

  assign full_now = (level == CNT_W'(DEPTH));
  assign pop_ok   = pop_req && (level != '0);
  assign ovf_evt  = push && full_now && !pop_ok;
  assign store    = push && (!ovf_evt || overwrite);
  assign drop_old = ovf_evt && overwrite;
  assign rd_adv   = pop_ok || drop_old;
  assign head     = slot[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (store) begin
      slot[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (store)  wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (rd_adv) rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      level <= CNT_W'(level_next(int'(level), store, rd_adv));
    end
  end

endmodule

// File: rtl/keyevt_flags.sv
module keyevt_flags
  import keyevt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_in,
  input  logic            ovf_evt,
  input  logic            level_zero,
  input  logic [ST_W-1:0] clr_req,
  input  cfg_t            cfg,
  output logic [ST_W-1:0] flags,
  output logic            irq
);

  logic [ST_W-1:0] set_v;
  logic [ST_W-1:0] allow_v;
  logic [ST_W-1:0] en_v;

  always_comb begin
    set_v           = '0;
    set_v[ST_KE]    = evt_in;
    set_v[ST_OVF]   = ovf_evt;
    allow_v         = '1;
    allow_v[ST_KE]  = level_zero;
    en_v            = '0;
    en_v[ST_KE]     = cfg.ke_ien;
    en_v[ST_OVF]    = cfg.ovf_ien;
  end

  for (genvar g = 0; g < ST_W; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           flags[g] <= 1'b0;
      else if (set_v[g])                    flags[g] <= 1'b1;
      else if (clr_req[g] && allow_v[g])    flags[g] <= 1'b0;
    end
  end

  assign irq = irq_merge(flags, en_v);

endmodule

// File: rtl/keyevt_host.sv
module keyevt_host
  import keyevt_pkg::*;
#(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      head,
  input  logic [CNT_W-1:0]  level,
  input  logic [ST_W-1:0]   flags,
  output cfg_t              cfg,
  output logic [ST_W-1:0]   clr_req,
  output logic              evt_hit,
  output logic              pop_req,
  output logic [DATA_W-1:0] rdata
);

  assign evt_hit = in_evt_window(int'(addr), DEPTH);
  assign pop_req = rd && evt_hit;
  assign clr_req = (wr && addr == ADDR_W'(ADR_STAT)) ? wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cfg <= '0;
    else if (wr && addr == ADDR_W'(ADR_CFG)) cfg <= cfg_t'(wdata[CFG_W-1:0]);
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (evt_hit) begin
        if (level != '0) rdata = DATA_W'(head);
      end else begin
        case (int'(addr))
          ADR_CFG:  rdata = DATA_W'(cfg);
          ADR_STAT: rdata = DATA_W'(flags);
          ADR_CNT:  rdata = DATA_W'(level);
          default:  rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/keyevt_queue.sv
module keyevt_queue
  import keyevt_pkg::*;
#(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned KEY_W  = 7,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned W     = KEY_W + 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_press,
  input  logic [KEY_W-1:0]  ev_key,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);

  // named internal events, also watched by the checker
  logic [W-1:0]     head;
  logic [CNT_W-1:0] evt_count;
  logic             pop_req;
  logic             pop_ok;
  logic             ovf_evt;
  logic             evt_hit;
  logic [ST_W-1:0]  flags;
  logic [ST_W-1:0]  clr_req;
  cfg_t             cfg;
  logic             overwrite;
  logic             ke_flag;
  logic             ovf_flag;

  assign overwrite = cfg.ovf_mode;
  assign ke_flag   = flags[ST_KE];
  assign ovf_flag  = flags[ST_OVF];

  keyevt_ring #(.DEPTH(DEPTH), .W(W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_valid),
    .push_data ({ev_press, ev_key}),
    .pop_req   (pop_req),
    .overwrite (overwrite),
    .head      (head),
    .level     (evt_count),
    .pop_ok    (pop_ok),
    .ovf_evt   (ovf_evt)
  );

  keyevt_host #(.DEPTH(DEPTH), .W(W), .ADDR_W(ADDR_W)) u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (host_rd),
    .wr      (host_wr),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .head    (head),
    .level   (evt_count),
    .flags   (flags),
    .cfg     (cfg),
    .clr_req (clr_req),
    .evt_hit (evt_hit),
    .pop_req (pop_req),
    .rdata   (host_rdata)
  );

  keyevt_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_in     (ev_valid),
    .ovf_evt    (ovf_evt),
    .level_zero (evt_count == '0),
    .clr_req    (clr_req),
    .cfg        (cfg),
    .flags      (flags),
    .irq        (irq)
  );

endmodule

// File: rtl/keyevt_queue_chk.sv
module keyevt_queue_chk #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             host_rd,
  input logic             evt_hit,
  input logic [7:0]       host_rdata,
  input logic [CNT_W-1:0] evt_count,
  input logic             pop_ok,
  input logic             ovf_evt,
  input logic             overwrite,
  input logic             ke_flag,
  input logic             ovf_flag
);

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_count <= CNT_W'(DEPTH));

  // R4
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && evt_hit && evt_count == '0) |-> host_rdata == 8'h00);

  // R3
  pop_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !ev_valid) |=> evt_count == $past(evt_count) - 1'b1);

  // R11
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && ev_valid) |=> $stable(evt_count));

  // R6
  drop_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !overwrite) |=> (evt_count == CNT_W'(DEPTH)) && ovf_flag);

  // R7
  roll_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && overwrite) |=> (evt_count == CNT_W'(DEPTH)) && ovf_flag);

  // R9
  ke_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_count != '0) |-> ke_flag);

endmodule

bind keyevt_queue keyevt_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_valid   (ev_valid),
  .host_rd    (host_rd),
  .evt_hit    (evt_hit),
  .host_rdata (host_rdata),
  .evt_count  (evt_count),
  .pop_ok     (pop_ok),
  .ovf_evt    (ovf_evt),
  .overwrite  (overwrite),
  .ke_flag    (ke_flag),
  .ovf_flag   (ovf_flag)
);

// File: tb/sim_keyevt_queue.sv
`timescale 1ns/100ps
module sim_keyevt_queue;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_press = 1'b0;
  logic [6:0] ev_key = '0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyevt_queue u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_press(ev_press),
    .ev_key(ev_key), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  // vector: {op[1:0], addr[4:0], data[7:0], exp[7:0]}
  // op 0 = event (data is the event byte), 1 = write, 2 = read and compare
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {2'd1, 5'd0,  8'h01, 8'h00},   // enable key-event irq
    {2'd0, 5'd0,  8'h81, 8'h00},   // R2 press key 1
    {2'd0, 5'd0,  8'h8C, 8'h00},   // press key 12
    {2'd0, 5'd0,  8'h01, 8'h00},   // release key 1
    {2'd2, 5'd2,  8'h00, 8'h03},   // R5 count 3
    {2'd2, 5'd13, 8'h00, 8'h00},   // R3 non-event address
    {2'd2, 5'd2,  8'h00, 8'h03},   // R3 nothing removed
    {2'd2, 5'd3,  8'h00, 8'h81},   // R2 oldest first
    {2'd2, 5'd12, 8'h00, 8'h8C},   // R3 last alias
    {2'd2, 5'd7,  8'h00, 8'h01},   // R2 release bit 7 = 0
    {2'd2, 5'd5,  8'h00, 8'h00},   // R4 empty read
    {2'd2, 5'd2,  8'h00, 8'h00},   // R4 count stays 0
    {2'd2, 5'd1,  8'h00, 8'h01},   // R8 flag set
    {2'd1, 5'd1,  8'h01, 8'h00},   // clear key flag
    {2'd2, 5'd1,  8'h00, 8'h00},   // R8 cleared when empty
    {2'd2, 5'd0,  8'h00, 8'h01}    // cfg read back
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push_ev(input logic [7:0] w);
    @(negedge clk);
    ev_valid = 1'b1; ev_press = w[7]; ev_key = w[6:0];
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [7:0] e, input string req);
    logic [7:0] d;
    rd_reg(a, d);
    check(d === e, req, int'(d), int'(e));
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run completion)");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_expect(5'd0, 8'h00, "R1 cfg");
    rd_expect(5'd1, 8'h00, "R1 status");
    rd_expect(5'd2, 8'h00, "R1 count");
    #1 check(irq === 1'b0, "R1 irq", int'(irq), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][22:21])
        2'd0: push_ev(VEC[i][15:8]);
        2'd1: wr_reg(VEC[i][20:16], VEC[i][15:8]);
        default: rd_expect(VEC[i][20:16], VEC[i][7:0], $sformatf("vector %0d", i));
      endcase
    end

    // R6 discard mode overflow
    wr_reg(5'd0, 8'h00);
    for (int k = 1; k <= 10; k++) push_ev(8'h80 | 8'(k));
    push_ev(8'h55);
    rd_expect(5'd2, 8'h0A, "R6 count full");
    rd_expect(5'd1, 8'h03, "R6 overflow flag");
    for (int k = 1; k <= 10; k++) rd_expect(5'd4, 8'h80 | 8'(k), "R6 kept order");
    rd_expect(5'd4, 8'h00, "R6 new event discarded");
    wr_reg(5'd1, 8'h03);
    rd_expect(5'd1, 8'h00, "R12 overflow cleared");

    // R7 overwrite mode
    wr_reg(5'd0, 8'h04);
    for (int k = 1; k <= 10; k++) push_ev(8'h80 | 8'(k));
    push_ev(8'h0B);
    push_ev(8'h0C);
    rd_expect(5'd2, 8'h0A, "R7 count stays 10");
    rd_expect(5'd1, 8'h03, "R7 overflow flag");
    for (int k = 3; k <= 10; k++) rd_expect(5'd9, 8'h80 | 8'(k), "R7 rolled order");
    rd_expect(5'd9, 8'h0B, "R7 newest-1");
    rd_expect(5'd9, 8'h0C, "R7 newest");
    wr_reg(5'd1, 8'h03);
    wr_reg(5'd0, 8'h00);

    // R11 same-cycle push and pop
    push_ev(8'h21);
    push_ev(8'h22);
    @(negedge clk);
    ev_valid = 1'b1; ev_press = 1'b0; ev_key = 7'h23;
    host_rd = 1'b1; host_addr = 5'd4;
    #1 d = host_rdata;
    @(negedge clk);
    ev_valid = 1'b0; host_rd = 1'b0;
    check(d === 8'h21, "R11 pop data", int'(d), 'h21);
    rd_expect(5'd2, 8'h02, "R11 count unchanged");
    rd_expect(5'd4, 8'h22, "R11 order a");
    rd_expect(5'd4, 8'h23, "R11 order b");
    @(negedge clk);
    ev_valid = 1'b1; ev_press = 1'b1; ev_key = 7'h24;
    host_rd = 1'b1; host_addr = 5'd6;
    #1 d = host_rdata;
    @(negedge clk);
    ev_valid = 1'b0; host_rd = 1'b0;
    check(d === 8'h00, "R11 empty pop data", int'(d), 0);
    rd_expect(5'd2, 8'h01, "R11 empty count 1");

    // R9 flag held while events remain
    wr_reg(5'd1, 8'h01);
    rd_expect(5'd1, 8'h01, "R9 flag held");
    rd_expect(5'd3, 8'hA4, "R9 drain");
    wr_reg(5'd1, 8'h01);
    rd_expect(5'd1, 8'h00, "R8 flag cleared after drain");

    // R10 interrupt combining
    push_ev(8'h10);
    @(negedge clk); #1;
    check(irq === 1'b0, "R10 disabled", int'(irq), 0);
    wr_reg(5'd0, 8'h01);
    #1 check(irq === 1'b1, "R10 key-event enabled", int'(irq), 1);
    wr_reg(5'd0, 8'h02);
    #1 check(irq === 1'b0, "R10 only overflow enabled", int'(irq), 0);
    for (int k = 0; k < 10; k++) push_ev(8'h40);
    #1 check(irq === 1'b1, "R10 overflow irq", int'(irq), 1);
    wr_reg(5'd1, 8'h02);
    #1 check(irq === 1'b0, "R12 overflow irq cleared", int'(irq), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule